// File: doc/BRIEF.md
# Line B2 Parity Generator with Error Injection

This block sits in the transmit path of a byte-serial STS-N stream (N from 1 to 3) ahead of the scrambler. For every interleaved STS-1 it computes an even bit-interleaved parity byte over the bytes it sent in one frame. It then places that byte in the B2 position of the same STS-1 in the following frame. Section overhead bytes pass through and are left out of the parity.

The upstream framer supplies a frame-start pulse, the row and column of the current byte, and the byte itself. Columns are numbered in interleave order, so column `c` belongs to STS-1 number `c mod N`. There is one error-enable bit per STS-1. While a bit is set, each pulse of the error strobe arms a one-shot inversion of that STS-1's next B2 byte. A force input replaces every byte outside section overhead with all ones (line AIS). Each byte leaves exactly one clock after it enters.

Top module: `b2_bip8_gen`

## Requirements
- R1: Each input byte appears on `dout` one clock later. Section overhead bytes are rows 0 to 2 with column below 3·N. They always pass unchanged, and so do other non-B2 bytes while AIS is off.
- R2: The B2 byte of STS-1 `s` is at row 4, column `s`. It carries the even-parity BIP-8 of every non-section-overhead byte of the previous frame whose column modulo N equals `s`.
- R3: The parity is taken over the bytes actually sent. This includes the inserted B2 value (inverted or not) and AIS all-ones bytes.
- R4: While `rst` is high, `dout` is 0x00 and all parity state clears. The B2 bytes of the first frame after reset are therefore 0x00.
- R5: A strobe pulse with `err_en[s]` high arms STS-1 `s`. Its next B2 byte is sent bitwise inverted and the arming is consumed. Several pulses before that B2 byte give a single inversion.
- R6: A B2 byte is inverted only if `err_en[s]` is high in the B2 cycle itself. A strobe while `err_en[s]` is low has no effect. An arming whose enable has dropped by the B2 cycle is discarded at that B2 byte.
- R7: A strobe that coincides with the B2 byte of an enabled STS-1 inverts that same byte.
- R8: While `lais_frc` is high, every byte outside section overhead is sent as 0xFF, including B2. Section overhead still passes.
- R9: `sof` marks row 0, column 0. At that byte every accumulator is copied into its hold register and restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | First byte of a frame (row 0, column 0) |
| row | input | ROW_W | Row of the current byte, 0 to 8 |
| col | input | COL_W | Interleaved column of the current byte, 0 to 90·N−1 |
| din | input | 8 | Transmit byte before insertion |
| err_en | input | N_STS | Per-STS-1 B2 error-insert enable |
| err_stb | input | 1 | Error-rate strobe, one pulse per inversion |
| lais_frc | input | 1 | Force line AIS |
| dout | output | 8 | Byte with B2 inserted, before scrambling |

## Verification
On every cycle, the assertions check three things. Section overhead passes unchanged, AIS bytes are all ones, and a B2 byte of a disabled STS-1 equals its held parity. They also check that a coincident strobe flips the held parity, that armings are set and consumed, and that the hold registers take the accumulators at frame start. Whether the held parity is the correct BIP-8 of the previous frame can only be shown by the bench's frame scenarios. The same holds for whether that parity includes inserted and AIS bytes, for one-shot behaviour across several strobes, and for the first frame after reset. The bench shows these by running a model of the transmitted stream.

// File: rtl/b2_pkg.sv
package b2_pkg;
  localparam int FRAME_ROWS   = 9;
  localparam int COLS_PER_STS = 90;
  localparam int SOH_ROWS     = 3;
  localparam int OH_COLS      = 3;
  localparam int B2_ROW       = 4;
  localparam logic [7:0] AIS_BYTE = 8'hFF;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/b2_pos_dec.sv
module b2_pos_dec
  import b2_pkg::*;
#(
  parameter int N_STS = 3,
  parameter int ROW_W = 4,
  parameter int COL_W = 9,
  parameter int SEL_W = 2
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic             is_soh,
  output logic             is_b2,
  output logic [SEL_W-1:0] sts
);
  localparam logic [ROW_W-1:0] SOH_ROW_LIM = ROW_W'(SOH_ROWS);
  localparam logic [ROW_W-1:0] B2_ROW_IDX  = ROW_W'(B2_ROW);
  localparam logic [COL_W-1:0] OH_COL_LIM  = COL_W'(OH_COLS * N_STS);
  localparam logic [COL_W-1:0] N_COL       = COL_W'(N_STS);

  always_comb begin
    is_soh = (row < SOH_ROW_LIM) && (col < OH_COL_LIM);
    is_b2  = (row == B2_ROW_IDX) && (col < N_COL);
    sts    = SEL_W'(col % N_COL);
  end
endmodule

// File: rtl/b2_acc_bank.sv
module b2_acc_bank
  import b2_pkg::*;
#(
  parameter int N_STS = 3,
  parameter int SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sof,
  input  logic                  cov,
  input  logic [SEL_W-1:0]      sts,
  input  byte_t                 tx_byte,
  output logic [N_STS-1:0][7:0] hold
);
  logic [N_STS-1:0][7:0] acc;

  for (genvar s = 0; s < N_STS; s++) begin : g_acc
    logic mine;
    assign mine = cov && (sts == SEL_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        acc[s]  <= '0;
        hold[s] <= '0;
      end else if (sof) begin
        hold[s] <= acc[s];
        acc[s]  <= mine ? tx_byte : 8'h00;
      end else if (mine) begin
        acc[s]  <= acc[s] ^ tx_byte;
      end
    end

    AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (rst)
      sof |=> hold[s] == $past(acc[s])); // R9
    AST_ACC_SKIP: assert property (@(posedge clk) disable iff (rst)
      (!cov && !sof) |=> acc[s] == $past(acc[s])); // R2
  end
endmodule

// File: rtl/b2_err_arm.sv
module b2_err_arm #(
  parameter int N_STS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_STS-1:0] en,
  input  logic             stb,
  input  logic [N_STS-1:0] hit,
  output logic [N_STS-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend | (en & {N_STS{stb}})) & ~hit;
  end

  for (genvar s = 0; s < N_STS; s++) begin : g_chk
    AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (rst)
      hit[s] |=> !pend[s]); // R5
    AST_ARM_SET: assert property (@(posedge clk) disable iff (rst)
      (stb && en[s] && !hit[s]) |=> pend[s]); // R5
  end
endmodule

// File: rtl/b2_bip8_gen.sv
module b2_bip8_gen
  import b2_pkg::*;
#(
  parameter int N_STS = 3,
  parameter int ROW_W = 4,
  parameter int COL_W = $clog2(COLS_PER_STS * N_STS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [7:0]       din,
  input  logic [N_STS-1:0] err_en,
  input  logic             err_stb,
  input  logic             lais_frc,
  output logic [7:0]       dout
);
  localparam int SEL_W = (N_STS > 1) ? $clog2(N_STS) : 1;

  logic                  is_soh;
  logic                  is_b2;
  logic [SEL_W-1:0]      sts;
  logic [N_STS-1:0]      hit;
  logic [N_STS-1:0]      pend;
  logic [N_STS-1:0][7:0] hold;
  byte_t                 hold_sel;
  byte_t                 tx;
  logic                  flip;

  b2_pos_dec #(.N_STS(N_STS), .ROW_W(ROW_W), .COL_W(COL_W), .SEL_W(SEL_W)) u_dec (
    .row(row), .col(col), .is_soh(is_soh), .is_b2(is_b2), .sts(sts)
  );

  for (genvar s = 0; s < N_STS; s++) begin : g_hit
    assign hit[s] = is_b2 && (sts == SEL_W'(s));
  end

  always_comb begin
    hold_sel = hold[sts];
    flip     = is_b2 && err_en[sts] && (pend[sts] || err_stb);
    if (is_soh)        tx = din;
    else if (lais_frc) tx = AIS_BYTE;
    else if (is_b2)    tx = hold_sel ^ {8{flip}};
    else               tx = din;
  end

  b2_acc_bank #(.N_STS(N_STS), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst(rst), .sof(sof), .cov(!is_soh), .sts(sts),
    .tx_byte(tx), .hold(hold)
  );

  b2_err_arm #(.N_STS(N_STS)) u_arm (
    .clk(clk), .rst(rst), .en(err_en), .stb(err_stb), .hit(hit), .pend(pend)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= tx;
  end

  AST_SOH_PASS: assert property (@(posedge clk) disable iff (rst)
    is_soh |=> dout == $past(din)); // R1
  AST_AIS_ONES: assert property (@(posedge clk) disable iff (rst)
    (lais_frc && !is_soh) |=> dout == 8'hFF); // R8
  AST_B2_PLAIN: assert property (@(posedge clk) disable iff (rst)
    (is_b2 && !lais_frc && !err_en[sts]) |=> dout == $past(hold_sel)); // R6
  AST_B2_FLIP_NOW: assert property (@(posedge clk) disable iff (rst)
    (is_b2 && !lais_frc && err_en[sts] && err_stb) |=> dout == ~$past(hold_sel)); // R7
endmodule

// File: tb/tb_b2_bip8_gen.sv
module tb_b2_bip8_gen;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 3;
  localparam int COLS = 90 * N;
  localparam int CW   = 9;

  typedef struct packed {
    logic       ais;
    logic [2:0] en_a;
    logic [2:0] en_b;
    logic [3:0] s_row;
    logic [8:0] s_col;
    logic [8:0] s_col2;
    logic       s_on;
    logic [2:0] inv;
    logic [7:0] seed;
  } vec_t;

  // stimulus per frame plus the expected inversion mask of its B2 bytes
  localparam vec_t TBL [7] = '{
    '{1'b0, 3'b000, 3'b000, 4'd0, 9'd0,   9'd0,   1'b0, 3'b000, 8'd11},
    '{1'b0, 3'b010, 3'b010, 4'd0, 9'd5,   9'd9,   1'b1, 3'b010, 8'd23},
    '{1'b0, 3'b010, 3'b000, 4'd0, 9'd5,   9'd5,   1'b1, 3'b000, 8'd37},
    '{1'b0, 3'b101, 3'b101, 4'd4, 9'd0,   9'd0,   1'b1, 3'b101, 8'd41},
    '{1'b1, 3'b000, 3'b000, 4'd0, 9'd0,   9'd0,   1'b0, 3'b000, 8'd53},
    '{1'b0, 3'b111, 3'b111, 4'd2, 9'd200, 9'd200, 1'b1, 3'b111, 8'd67},
    '{1'b0, 3'b000, 3'b000, 4'd0, 9'd0,   9'd0,   1'b0, 3'b000, 8'd79}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sof = 1'b0;
  logic [3:0]    row = '0;
  logic [CW-1:0] col = '0;
  logic [7:0]    din = '0;
  logic [N-1:0]  err_en = '0;
  logic          err_stb = 1'b0;
  logic          lais_frc = 1'b0;
  logic [7:0]    dout;

  int total = 0;
  int fails = 0;
  logic [7:0] exp_hold [N];
  logic [7:0] exp_acc  [N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  b2_bip8_gen dut (
    .clk(clk), .rst(rst), .sof(sof), .row(row), .col(col), .din(din),
    .err_en(err_en), .err_stb(err_stb), .lais_frc(lais_frc), .dout(dout)
  );

  function automatic logic [7:0] gen(input logic [7:0] sd, input int r, input int c);
    int v;
    v = int'(sd) * 37 + r * 29 + c * 5 + (c >> 2) * 3;
    return v[7:0] ^ sd;
  endfunction

  task automatic check(input logic ok, input string what, input logic [7:0] act, input logic [7:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", what, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < N; s++) begin
      exp_hold[s] = 8'h00;
      exp_acc[s]  = 8'h00;
    end
  endtask

  task automatic run_frame(input vec_t v);
    int bad = 0;
    logic [7:0] bad_act = 8'h00;
    logic [7:0] bad_exp = 8'h00;
    string tag;
    for (int r = 0; r < 9; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int s;
        logic soh, b2;
        logic [7:0] e;
        s   = c % N;
        soh = (r < 3) && (c < 3 * N);
        b2  = (r == 4) && (c < N);
        sof      = (r == 0) && (c == 0);
        row      = 4'(r);
        col      = CW'(c);
        din      = gen(v.seed, r, c);
        err_en   = (r < 3) ? v.en_a : v.en_b;
        err_stb  = v.s_on && (r == int'(v.s_row)) && (c == int'(v.s_col) || c == int'(v.s_col2));
        lais_frc = v.ais;
        if (r == 0 && c == 0) begin
          for (int k = 0; k < N; k++) begin
            exp_hold[k] = exp_acc[k];
            exp_acc[k]  = 8'h00;
          end
        end
        if (soh)        e = din;
        else if (v.ais) e = 8'hFF;
        else if (b2)    e = exp_hold[s] ^ {8{v.inv[s]}};
        else            e = din;
        if (!soh) exp_acc[s] = exp_acc[s] ^ e;
        @(negedge clk);
        if (b2) begin
          if (v.ais)            tag = "R8 B2";
          else if (v.inv != 0)  tag = "R5 R6 R7 B2";
          else                  tag = "R2 R3 R6 R9 B2";
          check(dout == e, $sformatf("%s sts%0d seed%0d", tag, s, v.seed), dout, e);
        end else if (dout !== e) begin
          if (bad == 0) begin
            bad_act = dout;
            bad_exp = e;
          end
          bad++;
        end
      end
    end
    check(bad == 0, $sformatf("R1 R8 stream bytes seed%0d (%0d bad)", v.seed, bad), bad_act, bad_exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    model_reset();
    din = 8'hAA;
    repeat (3) @(negedge clk);
    check(dout == 8'h00, "R4 dout during reset", dout, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < 7; i++) run_frame(TBL[i]);

    // directed: reset in the middle of traffic clears parity state
    rst = 1'b1;
    din = 8'h55;
    lais_frc = 1'b1;
    sof = 1'b0;
    @(negedge clk);
    check(dout == 8'h00, "R4 dout after mid-run reset", dout, 8'h00);
    rst = 1'b0;
    model_reset();
    run_frame('{1'b0, 3'b000, 3'b000, 4'd0, 9'd0, 9'd0, 1'b0, 3'b000, 8'd91});
    run_frame('{1'b0, 3'b000, 3'b000, 4'd0, 9'd0, 9'd0, 1'b0, 3'b000, 8'd101});

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule